// File: doc/BRIEF.md
# Tracking Error Built-In-Test Monitor

This block sits beside one channel of an angle-tracking converter. It watches that channel's signed tracking error and drives an active-low health line. On each sample strobe the magnitude of the error word passes through a first-order low-pass filter. The filter's time constant is about 500 µs at the configured sample rate. The filtered value is compared against a fixed threshold of 100 LSBs. A large step in the input therefore pulls the line low, and the line returns high by itself once the loop has settled.

Two other conditions also force a fault. The first is a loss-of-signal indication, which bypasses the filter entirely. The second is an overvelocity slip: the error swings from one large polarity to the other between consecutive samples, which shows the loop has lost input/output sync. A slip loads the filter with its full-scale value, so the fault holds until the filter has decayed again.

Top module: `trk_bit_monitor`

## Requirements
- R1: After reset, and until the first sample strobe, `fault_n` is 0.
- R2: The magnitude fed to the filter is the absolute value of the two's-complement error. The most negative code is saturated to the largest positive magnitude, 2^(ERR_W-1)-1.
- R3: On a strobe without a slip, the filter state y becomes y + floor((m - y) / 2^K), where m is the magnitude and the state resets to 0. K is the smallest k ≥ 1 with 2^k ≥ SAMPLE_HZ·TC_US/10^6. With the defaults (16000 Hz, 500 µs) K is 3.
- R4: One clock after a strobe, `fault_n` is 0 when the new filter state is strictly greater than THRESH (default 100). A state equal to THRESH reads healthy.
- R5: When `los` is 1 at a clock edge, `fault_n` is 0 after that edge, whatever the filter holds. The filter keeps updating on strobes while `los` is high.
- R6: A slip is declared when two consecutive strobed samples both have a magnitude of at least 2^(ERR_W-2) and opposite sign bits. On a slip the filter state is loaded with 2^(ERR_W-1)-1.
- R7: The fault is not latched. Once the filter state falls to THRESH or below and `los` is 0, `fault_n` returns to 1.
- R8: Without a strobe, `err_in` is ignored and the filter state holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | One-cycle strobe marking a valid error sample |
| err_in | input | ERR_W | Signed tracking error in LSBs |
| los | input | 1 | Loss of all input signals, active high |
| fault_n | output | 1 | Registered health line, 0 = fault |

## Verification
A slow ramp of error values through ±130 moves the filter state across the threshold from both sides. This separates strictly-greater from greater-or-equal comparisons and catches errors in the sign of the magnitude. Two slip-driven decays settle exactly on 100 and on 101. Only the strictly-greater rule gives opposite results for these two cases, and the length of each decay shows whether the full-scale load happened. Repeated most-negative codes expose a magnitude that wraps instead of saturating. Loss-of-signal pulses, with and without strobes, check the bypass path. Long pseudo-random error streams, including strobe-free stretches with hostile `err_in` values, compare every output against an arithmetic model of the filter.

// File: rtl/trk_bit_pkg.sv
package trk_bit_pkg;

  // Smallest shift k >= 1 such that 2^k covers the number of samples in one time constant
  function automatic int tc_shift(input int sample_hz, input int tc_us);
    longint n;
    int     k;
    n = (longint'(sample_hz) * longint'(tc_us)) / 64'sd1000000;
    k = 1;
    for (int i = 1; i < 31; i++) begin
      if ((longint'(1) << i) < n) k = i + 1;
    end
    return k;
  endfunction

endpackage

// File: rtl/trk_bit_mag.sv
module trk_bit_mag #(
  parameter int ERR_W = 16
) (
  input  logic signed [ERR_W-1:0] err_in,
  output logic        [ERR_W-2:0] mag
);

  function automatic logic [ERR_W-2:0] sat_abs(input logic signed [ERR_W-1:0] v);
    logic [ERR_W-1:0] neg;
    if (!v[ERR_W-1]) return v[ERR_W-2:0];
    neg = ~v + 1'b1;
    if (neg[ERR_W-1]) return '1;
    return neg[ERR_W-2:0];
  endfunction

  assign mag = sat_abs(err_in);

endmodule

// File: rtl/trk_bit_slip.sv
module trk_bit_slip #(
  parameter int ERR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_stb,
  input  logic signed [ERR_W-1:0] err_in,
  input  logic        [ERR_W-2:0] mag,
  output logic                    slip_hit
);

  localparam logic [ERR_W-2:0] BIG_V = {1'b1, {(ERR_W-2){1'b0}}};

  logic big, neg, prev_big_q, prev_neg_q;

  assign big      = (mag >= BIG_V);
  assign neg      = err_in[ERR_W-1];
  assign slip_hit = sample_stb & big & prev_big_q & (neg ^ prev_neg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_big_q <= 1'b0;
      prev_neg_q <= 1'b0;
    end else if (sample_stb) begin
      prev_big_q <= big;
      prev_neg_q <= neg;
    end
  end

endmodule

// File: rtl/trk_bit_iir.sv
module trk_bit_iir #(
  parameter int MAG_W = 15,
  parameter int SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_stb,
  input  logic [MAG_W-1:0] mag,
  input  logic             load_max,
  output logic [MAG_W-1:0] filt_q,
  output logic [MAG_W-1:0] filt_next
);

  // y + floor((m - y) / 2^SHIFT), kept inside [min(y,m), max(y,m)]
  function automatic logic [MAG_W-1:0] iir_step(input logic [MAG_W-1:0] y,
                                                input logic [MAG_W-1:0] m);
    logic signed [MAG_W:0] diff, step, sum;
    diff = $signed({1'b0, m}) - $signed({1'b0, y});
    step = diff >>> SHIFT;
    sum  = $signed({1'b0, y}) + step;
    return sum[MAG_W-1:0];
  endfunction

  always_comb begin
    if (!sample_stb)   filt_next = filt_q;
    else if (load_max) filt_next = '1;
    else               filt_next = iir_step(filt_q, mag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filt_q <= '0;
    else        filt_q <= filt_next;
  end

endmodule

// File: rtl/trk_bit_monitor.sv
module trk_bit_monitor
  import trk_bit_pkg::*;
#(
  parameter int ERR_W     = 16,
  parameter int SAMPLE_HZ = 16000,
  parameter int TC_US     = 500,
  parameter int THRESH    = 100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_stb,
  input  logic signed [ERR_W-1:0] err_in,
  input  logic                    los,
  output logic                    fault_n
);

  localparam int               MAG_W = ERR_W - 1;
  localparam int               SHIFT = tc_shift(SAMPLE_HZ, TC_US);
  localparam logic [MAG_W-1:0] THR_V = MAG_W'(THRESH);

  logic [MAG_W-1:0] mag;
  logic [MAG_W-1:0] filt_q, filt_next;
  logic             slip_hit;
  logic             over_thr;
  logic             primed_q, primed_d;
  logic             fault_n_q;

  trk_bit_mag #(.ERR_W(ERR_W)) u_mag (
    .err_in (err_in),
    .mag    (mag)
  );

  trk_bit_slip #(.ERR_W(ERR_W)) u_slip (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .err_in     (err_in),
    .mag        (mag),
    .slip_hit   (slip_hit)
  );

  trk_bit_iir #(.MAG_W(MAG_W), .SHIFT(SHIFT)) u_iir (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .mag        (mag),
    .load_max   (slip_hit),
    .filt_q     (filt_q),
    .filt_next  (filt_next)
  );

  assign over_thr = (filt_next > THR_V);
  assign primed_d = primed_q | sample_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q  <= 1'b0;
      fault_n_q <= 1'b0;
    end else begin
      primed_q  <= primed_d;
      fault_n_q <= ~(los | ~primed_d | over_thr);
    end
  end

  assign fault_n = fault_n_q;

endmodule

// File: rtl/trk_bit_monitor_chk.sv
module trk_bit_monitor_chk #(
  parameter int MAG_W  = 15,
  parameter int THRESH = 100
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_stb,
  input logic             los,
  input logic             fault_n,
  input logic             primed,
  input logic             slip_hit,
  input logic [MAG_W-1:0] filt_q,
  input logic [MAG_W-1:0] mag
);

  localparam logic [MAG_W-1:0] THR_V = MAG_W'(THRESH);
  localparam logic [MAG_W-1:0] MAX_V = '1;

  assert_unprimed_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !fault_n);

  assert_filter_rises_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !slip_hit && (mag >= filt_q)) |=> (filt_q >= $past(filt_q)));

  assert_threshold_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(los)) |-> (fault_n == (filt_q <= THR_V)));

  assert_los_forces_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    los |=> !fault_n);

  assert_slip_loads_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slip_hit |=> (filt_q == MAX_V));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(filt_q));

endmodule

bind trk_bit_monitor trk_bit_monitor_chk #(.MAG_W(MAG_W), .THRESH(THRESH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_stb (sample_stb),
  .los        (los),
  .fault_n    (fault_n),
  .primed     (primed_q),
  .slip_hit   (slip_hit),
  .filt_q     (filt_q),
  .mag        (mag)
);

// File: tb/trk_bit_monitor_bench.sv
module trk_bit_monitor_bench;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               sample_stb = 1'b0;
  logic signed [15:0] err_in = '0;
  logic               los = 1'b0;
  logic               fault_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  int y = 0;
  bit prev_big = 0;
  bit prev_neg = 0;
  int seed = 32'h1234_5678;

  always #4 clk = ~clk;

  trk_bit_monitor u_trk_bit_monitor (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .err_in     (err_in),
    .los        (los),
    .fault_n    (fault_n)
  );

  function automatic int floor_div8(input int d);
    if (d >= 0) return d / 8;
    return -((-d + 7) / 8);
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s fault_n actual %0b expected %0b (model y=%0d)", req, got, exp, y);
    end
  endtask

  // drive one strobed sample, advance the model, check one clock later
  task automatic sample(input int e, input logic l, input string req);
    int m;
    bit big, neg;
    @(negedge clk);
    err_in = e[15:0];
    los = l;
    sample_stb = 1'b1;
    m = (e < 0) ? -e : e;
    if (m > 32767) m = 32767;
    big = (m >= 16384);
    neg = (e < 0);
    if (prev_big && big && (neg != prev_neg)) y = 32767;
    else y = y + floor_div8(m - y);
    prev_big = big;
    prev_neg = neg;
    @(negedge clk);
    sample_stb = 1'b0;
    check(fault_n, !(l || (y > 100)), req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset and pre-sample state
    repeat (4) @(negedge clk);
    check(fault_n, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(fault_n, 1'b0, "R1 before first strobe");
    sample(0, 1'b0, "R1 first sample healthy");

    // R2 R3 R4: slow ramp across both threshold sides
    for (int v = -130; v <= 130; v++) sample(v, 1'b0, "R3 ramp");
    for (int i = 0; i < 40; i++) sample(115, 1'b0, "R4 hold above");
    for (int i = 0; i < 40; i++) sample(-96, 1'b0, "R2 negative hold");

    // R6 + R4/R7: slip then decay onto exactly 100
    sample(20000, 1'b0, "R6 first big");
    sample(-20000, 1'b0, "R6 slip");
    while (y != 100) sample(100, 1'b0, "R7 decay to 100");
    check(fault_n, 1'b1, "R4 equal to threshold healthy");

    // slip then decay onto 101 (strictly greater -> fault)
    sample(-17000, 1'b0, "R6 big negative");
    sample(17000, 1'b0, "R6 slip reverse");
    while (y != 101) sample(101, 1'b0, "R7 decay to 101");
    check(fault_n, 1'b0, "R4 101 above threshold");
    sample(100, 1'b0, "R7 clears at 100");
    check(fault_n, 1'b1, "R7 self clear");

    // R6 negatives: same sign, and separated big samples
    for (int i = 0; i < 60; i++) sample(0, 1'b0, "R7 settle");
    sample(20000, 1'b0, "R6 same sign a");
    sample(20000, 1'b0, "R6 same sign b");
    sample(5, 1'b0, "R6 small between");
    sample(-20000, 1'b0, "R6 not consecutive");
    for (int i = 0; i < 80; i++) sample(0, 1'b0, "R6 decay compare");

    // R2: most negative code saturates
    for (int i = 0; i < 20; i++) sample(-32768, 1'b0, "R2 min code");
    for (int i = 0; i < 90; i++) sample(-3, 1'b0, "R2 decay after min");

    // R5: los with and without strobes
    sample(0, 1'b1, "R5 los with strobe");
    sample(0, 1'b1, "R5 los with strobe 2");
    sample(0, 1'b0, "R5 los released");
    @(negedge clk);
    los = 1'b1;
    @(negedge clk);
    check(fault_n, 1'b0, "R5 los without strobe");
    los = 1'b0;
    @(negedge clk);
    check(fault_n, !(y > 100), "R5 release without strobe");
    for (int i = 0; i < 10; i++) sample(300, 1'b1, "R5 filter runs under los");
    sample(0, 1'b0, "R5 filter state after los");

    // R8: no strobe, hostile err_in ignored
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      err_in = (i[0]) ? 16'sh7fff : 16'sh8000;
      @(negedge clk);
      check(fault_n, !(y > 100), "R8 idle ignores err_in");
    end
    sample(0, 1'b0, "R8 state kept after idle");

    // pseudo-random stream with idle gaps
    for (int i = 0; i < 3000; i++) begin
      int e;
      seed = seed * 1103515245 + 12345;
      e = int'($signed(seed[23:8]));
      if (seed[26]) e = e / 256;
      if (seed[27] && seed[28]) begin
        @(negedge clk);
        err_in = seed[15:0];
      end
      sample(e, (seed[30:29] == 2'b11) && seed[5], "R3 random stream");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule